// File: doc/BRIEF.md
# Per-Thread Virtual Deadline Calculator

This block serves one thread of a fair-queuing memory scheduler. It models the memory system the thread would have if it owned the memory alone, with that memory running at a fraction φ of full speed. The model keeps a virtual-time register for each bank and one for the shared channel. For each arriving command it produces a virtual finish time. The scheduler uses that finish time as the request's deadline and arbitrates on earliest deadline first.

The bank stage starts a command no earlier than its arrival time and no earlier than the point the bank becomes free. It then adds the command's bank service time, stretched by 1/φ. The channel stage starts when both the bank result is done and the channel is free. It then adds the command's data-burst time, stretched the same way. Software programs the stretch factor as a fixed-point reciprocal of the share. The block accepts one command per cycle. It returns the four computed times one cycle later and updates its registers on that same edge, so a command that follows directly sees the state left by the one before it.

Top module: `vt_deadline_calc`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, every virtual-time register is zero, `resp_valid_o` is low and all response times read zero.
- R2: The bank start time equals the larger of `req_arrival_i` and the target bank's register.
- R3: The bank finish time equals the bank start time plus the scaled bank service time. The scaled value is (service × `recip_i`) shifted right by RECIP_FRAC bits, with the fractional bits dropped.
- R4: The channel start time equals the larger of the new bank finish time and the channel register. The channel finish time equals the channel start time plus the scaled channel service time.
- R5: The deadline equals the channel finish time. `resp_valid_o` and all response times appear on the cycle after the request is accepted.
- R6: An accepted request updates only its target bank register, to the bank finish time, and the channel register, to the channel finish time. All other bank registers keep their values.
- R7: A cycle with `req_valid_i` low produces no response and changes no register, whatever the other request inputs hold.
- R8: Requests on consecutive cycles are handled strictly in order. Each request sees the registers as updated by the one before it.
- R9: Command codes are 0 activate, 1 read, 2 write, 3 precharge. Their bank service times are 5, 5, 4 and 13. Reads and writes use 4 units of channel time; activates and precharges use none.
- R10: `recip_i` is unsigned with 8 fractional bits. 0x100 means full share (no stretch), 0x200 means half share, and 0x180 means 1.5 times the service time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present and accepted this cycle |
| req_cmd_i | input | 2 | Command code (R9) |
| req_bank_i | input | BANK_W | Target bank |
| req_arrival_i | input | VT_W | Arrival virtual time |
| recip_i | input | RECIP_W | Fixed-point reciprocal of the thread's share |
| resp_valid_o | output | 1 | Response valid |
| resp_bank_start_o | output | VT_W | Bank virtual start time |
| resp_bank_finish_o | output | VT_W | Bank virtual finish time |
| resp_chan_start_o | output | VT_W | Channel virtual start time |
| resp_deadline_o | output | VT_W | Deadline (channel virtual finish time) |

## Verification
The ordering assertions compare times as plain unsigned numbers. They therefore assume that no virtual time wraps past 2^VT_W. They include: start not before arrival, channel start not before bank finish, and channel time never moving backwards. The stimulus keeps every arrival time and share small, so every sum stays far below the register width. The stimulus includes non-integer shares, which exercise the truncation of fractional results. It also includes back-to-back requests to the same bank, an idle cycle with busy-looking inputs, and a reset in the middle of a run.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } vt_cmd_e;
endpackage

// File: rtl/vt_scale.sv
module vt_scale #(
  parameter int SVC_W      = 8,
  parameter int RECIP_W    = 16,
  parameter int RECIP_FRAC = 8,
  parameter int VT_W       = 32
) (
  input  logic [SVC_W-1:0]   svc_i,
  input  logic [RECIP_W-1:0] recip_i,
  output logic [VT_W-1:0]    scaled_o
);
  localparam int PROD_W = SVC_W + RECIP_W;
  localparam int INT_W  = PROD_W - RECIP_FRAC;

  logic [PROD_W-1:0] prod;
  logic [INT_W-1:0]  whole;

  always_comb begin
    prod  = PROD_W'(svc_i) * PROD_W'(recip_i);
    whole = prod[PROD_W-1:RECIP_FRAC];
  end

  generate
    if (INT_W >= VT_W) begin : g_trunc
      assign scaled_o = whole[VT_W-1:0];
    end else begin : g_ext
      assign scaled_o = {{(VT_W-INT_W){1'b0}}, whole};
    end
  endgenerate

  // R10: unit share leaves service time unchanged
  always_comb begin
    if (recip_i == RECIP_W'(1 << RECIP_FRAC))
      a_r10_unit_share: assert (scaled_o == VT_W'(svc_i));
  end
endmodule

// File: rtl/vt_bank_file.sv
module vt_bank_file #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int VT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] rd_sel_i,
  output logic [VT_W-1:0]   rd_vt_o,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_sel_i,
  input  logic [VT_W-1:0]   wr_vt_i
);
  logic [VT_W-1:0] vt_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        vt_q[b] <= '0;
      else if (wr_en_i && wr_sel_i == BANK_W'(b))
        vt_q[b] <= wr_vt_i;
    end

    a_r6_other_bank_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == BANK_W'(b)) |=> $stable(vt_q[b]));
  end

  assign rd_vt_o = vt_q[rd_sel_i];
endmodule

// File: rtl/vt_deadline_calc.sv
module vt_deadline_calc
  import vt_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int VT_W       = 32,
  parameter int RECIP_W    = 16,
  parameter int RECIP_FRAC = 8,
  parameter int SVC_W      = 8,
  parameter int T_ACT      = 5,
  parameter int T_RD       = 5,
  parameter int T_WR       = 4,
  parameter int T_PRE      = 13,
  parameter int T_BURST    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_cmd_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [VT_W-1:0]   req_arrival_i,
  input  logic [RECIP_W-1:0] recip_i,
  output logic              resp_valid_o,
  output logic [VT_W-1:0]   resp_bank_start_o,
  output logic [VT_W-1:0]   resp_bank_finish_o,
  output logic [VT_W-1:0]   resp_chan_start_o,
  output logic [VT_W-1:0]   resp_deadline_o
);
  vt_cmd_e          cmd;
  logic [VT_W-1:0]  bank_prev, bank_start, bank_finish, bank_scaled;
  logic [VT_W-1:0]  chan_q, chan_start, chan_finish, chan_scaled;
  logic [SVC_W-1:0] bank_svc, chan_svc;

  assign cmd = vt_cmd_e'(req_cmd_i);

  // R9: service table
  always_comb begin
    unique case (cmd)
      CMD_ACT: begin bank_svc = SVC_W'(T_ACT); chan_svc = '0;               end
      CMD_RD:  begin bank_svc = SVC_W'(T_RD);  chan_svc = SVC_W'(T_BURST);  end
      CMD_WR:  begin bank_svc = SVC_W'(T_WR);  chan_svc = SVC_W'(T_BURST);  end
      default: begin bank_svc = SVC_W'(T_PRE); chan_svc = '0;               end
    endcase
  end

  vt_bank_file #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .VT_W(VT_W)) u_banks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_sel_i (req_bank_i),
    .rd_vt_o  (bank_prev),
    .wr_en_i  (req_valid_i),
    .wr_sel_i (req_bank_i),
    .wr_vt_i  (bank_finish)
  );

  vt_scale #(.SVC_W(SVC_W), .RECIP_W(RECIP_W), .RECIP_FRAC(RECIP_FRAC), .VT_W(VT_W)) u_bank_scale (
    .svc_i    (bank_svc),
    .recip_i  (recip_i),
    .scaled_o (bank_scaled)
  );

  vt_scale #(.SVC_W(SVC_W), .RECIP_W(RECIP_W), .RECIP_FRAC(RECIP_FRAC), .VT_W(VT_W)) u_chan_scale (
    .svc_i    (chan_svc),
    .recip_i  (recip_i),
    .scaled_o (chan_scaled)
  );

  always_comb begin
    bank_start  = (req_arrival_i > bank_prev) ? req_arrival_i : bank_prev;
    bank_finish = bank_start + bank_scaled;
    chan_start  = (bank_finish > chan_q) ? bank_finish : chan_q;
    chan_finish = chan_start + chan_scaled;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q             <= '0;
      resp_valid_o       <= 1'b0;
      resp_bank_start_o  <= '0;
      resp_bank_finish_o <= '0;
      resp_chan_start_o  <= '0;
      resp_deadline_o    <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        chan_q             <= chan_finish;
        resp_bank_start_o  <= bank_start;
        resp_bank_finish_o <= bank_finish;
        resp_chan_start_o  <= chan_start;
        resp_deadline_o    <= chan_finish;
      end
    end
  end

  a_r5_resp_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  a_r7_idle_no_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!resp_valid_o && $stable(chan_q)));

  a_r2_start_covers_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_bank_start_o >= $past(req_arrival_i));

  a_r3_finish_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> resp_bank_finish_o >= resp_bank_start_o);

  a_r4_chan_after_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_chan_start_o >= resp_bank_finish_o &&
                      resp_deadline_o >= resp_chan_start_o));

  a_r8_chan_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> chan_q >= $past(chan_q));
endmodule

// File: tb/vt_deadline_calc_bench.sv
module vt_deadline_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cmd = '0;
  logic [2:0]  req_bank = '0;
  logic [31:0] req_arrival = '0;
  logic [15:0] recip = 16'h100;
  logic        resp_valid;
  logic [31:0] bs, bf, cs, dl;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vt_deadline_calc u_vt_deadline_calc (
    .clk_i              (clk),
    .rst_ni             (rst_n),
    .req_valid_i        (req_valid),
    .req_cmd_i          (req_cmd),
    .req_bank_i         (req_bank),
    .req_arrival_i      (req_arrival),
    .recip_i            (recip),
    .resp_valid_o       (resp_valid),
    .resp_bank_start_o  (bs),
    .resp_bank_finish_o (bf),
    .resp_chan_start_o  (cs),
    .resp_deadline_o    (dl)
  );

  typedef struct packed {
    logic [1:0]  cmd;
    logic [2:0]  bank;
    logic [31:0] arr;
    logic [15:0] recip;
    logic [31:0] bs, bf, cs, dl;
  } vec_t;

  // R9 codes, R10 shares; expected values worked from the requirements
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 32'd10,  16'h100, 32'd10,  32'd15,  32'd15,  32'd15},
    '{2'd1, 3'd0, 32'd12,  16'h100, 32'd15,  32'd20,  32'd20,  32'd24},
    '{2'd0, 3'd1, 32'd16,  16'h200, 32'd16,  32'd26,  32'd26,  32'd26},
    '{2'd2, 3'd1, 32'd20,  16'h200, 32'd26,  32'd34,  32'd34,  32'd42},
    '{2'd1, 3'd0, 32'd21,  16'h200, 32'd21,  32'd31,  32'd42,  32'd50},
    '{2'd3, 3'd0, 32'd22,  16'h180, 32'd31,  32'd50,  32'd50,  32'd50},
    '{2'd0, 3'd7, 32'd100, 16'h100, 32'd100, 32'd105, 32'd105, 32'd105},
    '{2'd1, 3'd7, 32'd101, 16'h0C0, 32'd105, 32'd108, 32'd108, 32'd111},
    '{2'd3, 3'd1, 32'd50,  16'h100, 32'd50,  32'd63,  32'd111, 32'd111},
    '{2'd2, 3'd2, 32'd200, 16'h155, 32'd200, 32'd205, 32'd205, 32'd210}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic [2:0] b, input logic [31:0] a, input logic [15:0] r);
    req_valid = 1'b1; req_cmd = c; req_bank = b; req_arrival = a; recip = r;
  endtask

  task automatic check_resp(input string tag, input logic [31:0] e_bs, input logic [31:0] e_bf,
                            input logic [31:0] e_cs, input logic [31:0] e_dl);
    chk({tag, " R5"}, "valid", 32'(resp_valid), 32'd1);
    chk({tag, " R2"}, "bank_start", bs, e_bs);
    chk({tag, " R3"}, "bank_finish", bf, e_bf);
    chk({tag, " R4"}, "chan_start", cs, e_cs);
    chk({tag, " R5"}, "deadline", dl, e_dl);
  endtask

  task automatic one(input logic [1:0] c, input logic [2:0] b, input logic [31:0] a, input logic [15:0] r,
                     input string tag, input logic [31:0] e_bs, input logic [31:0] e_bf,
                     input logic [31:0] e_cs, input logic [31:0] e_dl);
    @(negedge clk);
    drive(c, b, a, r);
    @(negedge clk);
    req_valid = 1'b0;
    check_resp(tag, e_bs, e_bf, e_cs, e_dl);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 32'(resp_valid), 32'd0);
    chk("R1", "deadline in reset", dl, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after release", 32'(resp_valid), 32'd0);
    chk("R1", "bank_start after release", bs, 32'd0);

    // R9 R10 table
    for (int i = 0; i < NV; i++)
      one(VECS[i].cmd, VECS[i].bank, VECS[i].arr, VECS[i].recip, "R9/R10 table",
          VECS[i].bs, VECS[i].bf, VECS[i].cs, VECS[i].dl);

    // R6: bank 3 untouched so far
    one(2'd0, 3'd3, 32'd0, 16'h100, "R6 untouched bank", 32'd0, 32'd5, 32'd210, 32'd210);

    // R7: idle cycle with busy-looking inputs
    @(negedge clk);
    req_valid = 1'b0; req_cmd = 2'd3; req_bank = 3'd2; req_arrival = 32'd999; recip = 16'hFFFF;
    @(negedge clk);
    chk("R7", "valid on idle", 32'(resp_valid), 32'd0);
    one(2'd1, 3'd2, 32'd0, 16'h100, "R7 state held", 32'd205, 32'd210, 32'd210, 32'd214);

    // R8: back-to-back on same bank
    @(negedge clk);
    drive(2'd2, 3'd2, 32'd0, 16'h100);
    @(negedge clk);
    drive(2'd1, 3'd2, 32'd0, 16'h100);
    check_resp("R8 first", 32'd210, 32'd214, 32'd214, 32'd218);
    @(negedge clk);
    req_valid = 1'b0;
    check_resp("R8 second", 32'd214, 32'd219, 32'd219, 32'd223);

    // R1: reset mid-run clears registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "valid in mid reset", 32'(resp_valid), 32'd0);
    chk("R1", "deadline in mid reset", dl, 32'd0);
    rst_n = 1'b1;
    one(2'd0, 3'd2, 32'd3, 16'h100, "R1 cleared", 32'd3, 32'd8, 32'd8, 32'd8);

    finish_run();
  end
endmodule